// File: doc/BRIEF.md
# Start-of-Frame Frame and Microframe Tracker

This block sits behind a bus packet decoder and follows the start-of-frame (SOF) tokens the host sends. Each decoded SOF arrives as a one-cycle strobe with an 11-bit frame number. The block registers that number and holds it between strobes, so software reads a stable value. In high-speed operation eight consecutive SOFs carry the same frame number, one every 125 µs. The block therefore keeps a separate 0–7 microframe index so that the slots inside one frame can be told apart. In full-speed operation one SOF arrives per millisecond and the index stays at zero.

Every accepted SOF produces a one-cycle interrupt pulse. Two sticky error flags report trouble on the bus. The first is a missed-SOF flag, raised by a local timeout whose length in clock cycles is the nominal period of the selected speed plus a margin. The second is a sequence flag, raised when a frame number arrives that the current speed does not allow. Software clears either flag by writing a one to its bit of the clear input. The speed is a static input that changes only while reset is held.

Top module: `sof_tracker`

## Requirements
- R1: While reset is high, the frame number, microframe index, interrupt, missed-SOF flag and sequence flag are all driven to zero.
- R2: The frame number on `sof_frame_i` is taken only in a cycle where `sof_valid_i` is high. It appears on `frame_num_o` after that clock edge and holds its value through every cycle without a strobe.
- R3: `sof_irq_o` is high for exactly the one cycle that follows each clock edge with `sof_valid_i` high, and low otherwise.
- R4: In high speed (`hs_mode_i` = 1), an SOF whose frame number equals the stored one increments `uframe_o` by one. The index saturates at 7.
- R5: The first SOF after reset sets `uframe_o` to 0. So does any SOF whose frame number differs from the stored one.
- R6: In full speed (`hs_mode_i` = 0), every SOF leaves `uframe_o` at 0.
- R7: After the first SOF, the block counts cycles. The limit is FS_PERIOD_CYC+MARGIN_CYC in full speed and HS_PERIOD_CYC+MARGIN_CYC in high speed. If the limit number of clock edges pass with no SOF, `miss_flag_o` is set and the count starts again. An SOF that arrives exactly the limit number of edges after the previous one does not set the flag. The flag is sticky.
- R8: Before the first SOF after reset, the timeout is not armed, and `miss_flag_o` stays low however long the bus is idle.
- R9: Bit 0 of `flag_clr_i` clears `miss_flag_o` and bit 1 clears `seq_err_o`. Each bit affects only its own flag. If a flag is set and cleared in the same cycle, the set wins.
- R10: In high speed, `seq_err_o` is set by an SOF whose frame number is neither the stored number nor the stored number plus one (modulo 2048). In full speed, it is set by any SOF other than the stored number plus one, repeats included. The first SOF after reset never sets it, and a wrap from 2047 to 0 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode_i | input | 1 | Speed select: 1 = high speed, 0 = full speed; static outside reset |
| sof_valid_i | input | 1 | One-cycle strobe for a decoded SOF |
| sof_frame_i | input | 11 | Frame number carried by the SOF |
| flag_clr_i | input | 2 | Write-one-to-clear: bit 0 clears the missed flag, bit 1 clears the sequence flag |
| frame_num_o | output | 11 | Registered frame number |
| uframe_o | output | 3 | Microframe index within the frame |
| sof_irq_o | output | 1 | One-cycle interrupt pulse per accepted SOF |
| miss_flag_o | output | 1 | Sticky missed-SOF flag |
| seq_err_o | output | 1 | Sticky unexpected-frame-number flag |

## Verification
The assertions assume that `hs_mode_i` changes only while `rst` is high. If it changed at run time, the timeout count could exceed the limit of the newly selected speed, and the microframe checks would no longer hold. The bench changes the speed only inside its reset task and holds reset for several cycles after the change. The assertions also assume that `sof_valid_i` is a strobe. The bench raises it for a single clock edge per SOF and keeps the gap between SOFs well under the timeout limit, except in the tests that are meant to expire it.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;

    localparam int FRAME_W = 11;
    localparam int UF_W    = 3;
    localparam int UF_MAX  = 7;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [UF_W-1:0]    uframe_t;

    typedef enum logic {
        SPD_FULL = 1'b0,
        SPD_HIGH = 1'b1
    } speed_e;

    typedef struct packed {
        logic   valid;
        frame_t num;
    } sof_ev_t;

    function automatic frame_t frame_succ(frame_t f);
        return f + frame_t'(1);
    endfunction

    function automatic uframe_t uf_step(uframe_t u);
        return (u == uframe_t'(UF_MAX)) ? u : u + uframe_t'(1);
    endfunction

endpackage

// File: rtl/sof_frame_ctr.sv
module sof_frame_ctr
    import sof_trk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  speed_e  speed,
    input  sof_ev_t ev,
    input  logic    clr_err,
    output frame_t  frame_o,
    output uframe_t uf_o,
    output logic    seq_err_o
);

    frame_t  frame_q;
    uframe_t uf_q;
    logic    seen_q;
    logic    err_q;

    logic    same_num;
    logic    succ_num;
    logic    bad_num;
    uframe_t uf_nxt;

    always_comb begin
        same_num = (ev.num == frame_q);
        succ_num = (ev.num == frame_succ(frame_q));
        if (!seen_q)
            bad_num = 1'b0;
        else if (speed == SPD_FULL)
            bad_num = !succ_num;
        else
            bad_num = !same_num && !succ_num;
        if (speed == SPD_HIGH && seen_q && same_num)
            uf_nxt = uf_step(uf_q);
        else
            uf_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            uf_q    <= '0;
            seen_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (ev.valid) begin
                frame_q <= ev.num;
                uf_q    <= uf_nxt;
                seen_q  <= 1'b1;
            end
            if (ev.valid && bad_num)
                err_q <= 1'b1;
            else if (clr_err)
                err_q <= 1'b0;
        end
    end

    assign frame_o   = frame_q;
    assign uf_o      = uf_q;
    assign seq_err_o = err_q;

    // R2
    frame_capture_chk: assert property (@(posedge clk) disable iff (rst)
        ev.valid |=> frame_o == $past(ev.num));
    // R2
    frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ev.valid |=> $stable(frame_o) && $stable(uf_o));
    // R6
    fs_uframe_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ev.valid && speed == SPD_FULL |=> uf_o == '0);
    // R5
    new_frame_uf_chk: assert property (@(posedge clk) disable iff (rst)
        ev.valid && ev.num != frame_o |=> uf_o == '0);
    // R10
    first_sof_clean_chk: assert property (@(posedge clk) disable iff (rst)
        ev.valid && !seen_q && !err_q && !clr_err |=> !seq_err_o);

endmodule

// File: rtl/sof_timeout.sv
module sof_timeout
    import sof_trk_pkg::*;
#(
    parameter int FS_LIMIT = 60600,
    parameter int HS_LIMIT = 8100
) (
    input  logic   clk,
    input  logic   rst,
    input  speed_e speed,
    input  logic   sof,
    input  logic   clr_miss,
    output logic   miss_o
);

    localparam int MAX_LIMIT = (FS_LIMIT > HS_LIMIT) ? FS_LIMIT : HS_LIMIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             armed_q;
    logic             miss_q;
    logic             expire;

    always_comb begin
        limit  = (speed == SPD_HIGH) ? CNT_W'(HS_LIMIT) : CNT_W'(FS_LIMIT);
        expire = armed_q && !sof && (cnt_q == limit - CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            if (sof) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
            end else if (expire) begin
                cnt_q <= '0;
            end else if (armed_q) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (expire)
                miss_q <= 1'b1;
            else if (clr_miss)
                miss_q <= 1'b0;
        end
    end

    assign miss_o = miss_q;

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q < limit);
    // R8
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !armed_q |-> !miss_o);
    // R7
    miss_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        miss_o && !clr_miss |=> miss_o);
    // R9
    miss_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_miss && !expire |=> !miss_o);

endmodule

// File: rtl/sof_tracker.sv
module sof_tracker
    import sof_trk_pkg::*;
#(
    parameter int FS_PERIOD_CYC = 60000,
    parameter int HS_PERIOD_CYC = 7500,
    parameter int MARGIN_CYC    = 600
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hs_mode_i,
    input  logic                sof_valid_i,
    input  logic [FRAME_W-1:0]  sof_frame_i,
    input  logic [1:0]          flag_clr_i,
    output logic [FRAME_W-1:0]  frame_num_o,
    output logic [UF_W-1:0]     uframe_o,
    output logic                sof_irq_o,
    output logic                miss_flag_o,
    output logic                seq_err_o
);

    localparam int FS_LIMIT = FS_PERIOD_CYC + MARGIN_CYC;
    localparam int HS_LIMIT = HS_PERIOD_CYC + MARGIN_CYC;

    speed_e  speed;
    sof_ev_t ev;
    logic    irq_q;

    assign speed    = speed_e'(hs_mode_i);
    assign ev.valid = sof_valid_i;
    assign ev.num   = sof_frame_i;

    sof_frame_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .speed     (speed),
        .ev        (ev),
        .clr_err   (flag_clr_i[1]),
        .frame_o   (frame_num_o),
        .uf_o      (uframe_o),
        .seq_err_o (seq_err_o)
    );

    sof_timeout #(
        .FS_LIMIT (FS_LIMIT),
        .HS_LIMIT (HS_LIMIT)
    ) u_tmo (
        .clk      (clk),
        .rst      (rst),
        .speed    (speed),
        .sof      (sof_valid_i),
        .clr_miss (flag_clr_i[0]),
        .miss_o   (miss_flag_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= sof_valid_i;
    end

    assign sof_irq_o = irq_q;

    // R3
    irq_on_sof_chk: assert property (@(posedge clk) disable iff (rst)
        sof_valid_i |=> sof_irq_o);
    // R3
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sof_valid_i |=> !sof_irq_o);

endmodule

// File: tb/sof_tracker_tb.sv
module sof_tracker_tb_top;

    localparam int FS_P   = 40;
    localparam int HS_P   = 10;
    localparam int MARG   = 4;
    localparam int FS_LIM = FS_P + MARG;
    localparam int HS_LIM = HS_P + MARG;

    typedef struct packed {
        logic [10:0] frame;
        logic [2:0]  exp_uf;
        logic        exp_err;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{11'd2046, 3'd0, 1'b0},
        '{11'd2046, 3'd1, 1'b0},
        '{11'd2046, 3'd2, 1'b0},
        '{11'd2046, 3'd3, 1'b0},
        '{11'd2046, 3'd4, 1'b0},
        '{11'd2046, 3'd5, 1'b0},
        '{11'd2046, 3'd6, 1'b0},
        '{11'd2046, 3'd7, 1'b0},
        '{11'd2046, 3'd7, 1'b0},
        '{11'd2047, 3'd0, 1'b0},
        '{11'd2047, 3'd1, 1'b0},
        '{11'd0,    3'd0, 1'b0},
        '{11'd3,    3'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hs_mode_i = 1'b1;
    logic        sof_valid_i = 1'b0;
    logic [10:0] sof_frame_i = '0;
    logic [1:0]  flag_clr_i = '0;
    logic [10:0] frame_num_o;
    logic [2:0]  uframe_o;
    logic        sof_irq_o;
    logic        miss_flag_o;
    logic        seq_err_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    sof_tracker #(
        .FS_PERIOD_CYC (FS_P),
        .HS_PERIOD_CYC (HS_P),
        .MARGIN_CYC    (MARG)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .hs_mode_i   (hs_mode_i),
        .sof_valid_i (sof_valid_i),
        .sof_frame_i (sof_frame_i),
        .flag_clr_i  (flag_clr_i),
        .frame_num_o (frame_num_o),
        .uframe_o    (uframe_o),
        .sof_irq_o   (sof_irq_o),
        .miss_flag_o (miss_flag_o),
        .seq_err_o   (seq_err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic hs);
        @(negedge clk);
        rst = 1'b1;
        hs_mode_i = hs;
        sof_valid_i = 1'b0;
        flag_clr_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_sof(input logic [10:0] f);
        @(negedge clk);
        sof_valid_i = 1'b1;
        sof_frame_i = f;
        @(negedge clk);
        sof_valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        @(negedge clk);
        flag_clr_i = m;
        @(negedge clk);
        flag_clr_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check(frame_num_o == 0 && uframe_o == 0 && !sof_irq_o && !miss_flag_o && !seq_err_o,
              "R1 reset outputs", {frame_num_o, uframe_o, sof_irq_o, miss_flag_o, seq_err_o}, 0);
        do_reset(1'b1);

        // High-speed table: R4, R5, R10, R3
        for (int i = 0; i < NV; i++) begin
            send_sof(VECS[i].frame);
            check(frame_num_o == VECS[i].frame, "R2 frame capture", frame_num_o, VECS[i].frame);
            check(uframe_o == VECS[i].exp_uf, "R4/R5 uframe", uframe_o, VECS[i].exp_uf);
            check(seq_err_o == VECS[i].exp_err, "R10 seq flag", seq_err_o, VECS[i].exp_err);
            check(sof_irq_o == 1'b1, "R3 irq high", sof_irq_o, 1);
            idle(1);
            check(sof_irq_o == 1'b0, "R3 irq one cycle", sof_irq_o, 0);
        end

        // R2: no strobe, changing input, value holds
        sof_frame_i = 11'd123;
        idle(3);
        check(frame_num_o == 11'd3, "R2 hold without strobe", frame_num_o, 3);
        check(miss_flag_o == 1'b0, "R7 no miss with short gaps", miss_flag_o, 0);

        // R9: clear seq flag only
        pulse_clr(2'b10);
        check(seq_err_o == 1'b0, "R9 seq clear", seq_err_o, 0);

        // R7: SOF exactly at the limit gap does not expire
        send_sof(11'd3);
        check(uframe_o == 3'd1, "R4 repeat number increments", uframe_o, 1);
        idle(HS_LIM - 2);
        send_sof(11'd3);
        check(miss_flag_o == 1'b0, "R7 exact-limit gap ok", miss_flag_o, 0);

        // R7: high-speed timeout
        idle(HS_LIM - 1);
        check(miss_flag_o == 1'b0, "R7 before HS limit", miss_flag_o, 0);
        idle(1);
        check(miss_flag_o == 1'b1, "R7 HS miss set", miss_flag_o, 1);
        idle(5);
        check(miss_flag_o == 1'b1, "R7 miss sticky", miss_flag_o, 1);
        pulse_clr(2'b01);
        check(miss_flag_o == 1'b0, "R9 miss clear", miss_flag_o, 0);
        check(seq_err_o == 1'b0, "R9 miss clear leaves seq", seq_err_o, 0);

        // R8: not armed before first SOF
        do_reset(1'b1);
        check(frame_num_o == 0 && uframe_o == 0 && !miss_flag_o, "R1 second reset",
              {frame_num_o, uframe_o, miss_flag_o}, 0);
        idle(3 * FS_LIM);
        check(miss_flag_o == 1'b0, "R8 idle before first SOF", miss_flag_o, 0);
        send_sof(11'd0);
        check(uframe_o == 3'd0 && seq_err_o == 1'b0, "R5 first SOF index zero",
              {uframe_o, seq_err_o}, 0);

        // Full speed: R6, R10
        do_reset(1'b0);
        send_sof(11'd100);
        send_sof(11'd101);
        check(uframe_o == 3'd0 && seq_err_o == 1'b0, "R6 FS successor", {uframe_o, seq_err_o}, 0);
        send_sof(11'd101);
        check(uframe_o == 3'd0, "R6 FS repeat index zero", uframe_o, 0);
        check(seq_err_o == 1'b1, "R10 FS repeat flagged", seq_err_o, 1);
        pulse_clr(2'b11);
        check(seq_err_o == 1'b0, "R9 seq clear FS", seq_err_o, 0);

        // R7 FS limit, R9 set wins over clear
        send_sof(11'd102);
        idle(FS_LIM - 1);
        check(miss_flag_o == 1'b0, "R7 before FS limit", miss_flag_o, 0);
        flag_clr_i = 2'b01;
        @(negedge clk);
        flag_clr_i = 2'b00;
        check(miss_flag_o == 1'b1, "R9 set wins over clear", miss_flag_o, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule